// File: doc/BRIEF.md
# Keyboard Matrix Sense Emulator

This block stands in for a physical scanned keyboard as seen by the controller that scans it. The controller drives a vector of strobe columns. The block answers on a set of sense rows: each row is high while any pressed key in that row sits on a strobe column that is currently active. Key activity arrives from the host side as compact event codes. These codes are already in row/column form, so no keycode translation takes place here.

Events do not take effect the moment they are pushed. They wait in a small circular queue, and a slow periodic tick removes one event at a time. One row number is not part of the matrix. Events that name it drive a small bank of discrete switch lines (lid, power, sync and similar buttons), and each line has a configurable polarity inversion. A release-all input empties the key matrix, for example when saved state is restored, and the sense rows then follow.

Top module: `kbd_matrix_emu`

## Requirements
- R1: After reset, all sense rows, all switch lines, the overflow flag and the inversion register are 0, the event queue is empty and no key is pressed.
- R2: An event code is 8 bits. Bit 7 set means release and bit 7 clear means press. Bits 6:4 give the row and bits 3:0 give the column. A press consumed for a matrix row sets that key and a release clears it.
- R3: Sense row i is registered. In each cycle it takes the OR over columns of (pressed keys of row i AND strobe vector) as they stood in the previous cycle, so it follows a strobe or key change one cycle later.
- R4: An event whose row field is 7 leaves the matrix unchanged. For column c below 5 it sets switch line c to (press XOR inversion bit c), using the inversion bit held before that cycle's edge.
- R5: A matrix event with a column of 11 or more, or a row-7 event with a column of 5 or more, changes nothing.
- R6: A tick occurs on every TICK_DIV-th clock after reset, the first one in the TICK_DIV-th cycle. Each tick removes at most one queued event, oldest first, and applies it at that edge. Switch lines change only on those edges.
- R7: The queue holds 16 events. A push while the queue is full is dropped and sets a sticky overflow flag, unless a tick removes an event in the same cycle, in which case the push is accepted. The flag clears only at reset.
- R8: Release-all clears every matrix key at the next edge, and the sense rows read 0 from the cycle after. If an event is removed in that same cycle, it is discarded. Switch lines keep their values.
- R9: The inversion register loads inv_data_i when inv_we_i is high. A new value affects only switch events applied after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_push_i | input | 1 | Push key_code_i into the event queue |
| key_code_i | input | 8 | Event code (release, row, column) |
| strobe_i | input | 11 | Strobe columns driven by the scanning controller |
| release_all_i | input | 1 | Release every matrix key |
| inv_we_i | input | 1 | Write the switch inversion register |
| inv_data_i | input | 5 | New inversion bits, one per switch line |
| sense_o | output | 7 | Sense rows |
| switch_o | output | 5 | Discrete switch lines |
| overflow_o | output | 1 | Sticky queue overflow flag |

## Verification
The hardest case to reach is release-all landing in the same cycle as a tick that removes a pending key event. Here the clear must win and the event must vanish without a trace. The bench keeps its own tick counter in step with the design. It holds a press in the queue and raises release-all exactly in the cycle before the tick edge, then shows through the sense rows, with every strobe active, that the key never appears. A full queue that receives a push in the very cycle a tick frees a slot is reached the same way: the queue is filled in a burst that runs across a tick.

// File: rtl/kbd_pkg.sv
package kbd_pkg;

    // Event code layout: release flag, row field, column field
    typedef struct packed {
        logic       rel;
        logic [2:0] row;
        logic [3:0] col;
    } kbd_event_t;

    localparam int EVENT_W = $bits(kbd_event_t);

endpackage

// File: rtl/kbd_tick.sv
module kbd_tick #(
    parameter int TICK_DIV = 1562500
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tick_st_t;

    tick_st_t st_d, st_q;
    logic     wrap;

    always_comb begin
        st_d = st_q;
        wrap = (st_q.cnt == CW'(TICK_DIV - 1));
        if (wrap) st_d.cnt = '0;
        else      st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_o = wrap;

endmodule

// File: rtl/kbd_fifo.sv
module kbd_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] data_i,
    input  logic         pop_i,
    output logic [W-1:0] data_o,
    output logic         empty_o,
    output logic         ovf_o
);
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           rd;
        logic [AW-1:0]           wr;
        logic [CNTW-1:0]         count;
        logic                    ovf;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     full, do_pop, do_push;

    always_comb begin
        st_d    = st_q;
        full    = (st_q.count == CNTW'(DEPTH));
        do_pop  = pop_i && (st_q.count != '0);
        do_push = push_i && (!full || do_pop);
        if (do_pop)
            st_d.rd = (st_q.rd == AW'(DEPTH - 1)) ? '0 : st_q.rd + 1'b1;
        if (do_push) begin
            st_d.mem[st_q.wr] = data_i;
            st_d.wr = (st_q.wr == AW'(DEPTH - 1)) ? '0 : st_q.wr + 1'b1;
        end
        if (push_i && !do_push)
            st_d.ovf = 1'b1;
        case ({do_push, do_pop})
            2'b10:   st_d.count = st_q.count + 1'b1;
            2'b01:   st_d.count = st_q.count - 1'b1;
            default: st_d.count = st_q.count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_o  = st_q.mem[st_q.rd];
    assign empty_o = (st_q.count == '0);
    assign ovf_o   = st_q.ovf;

    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ovf |=> st_q.ovf);

    // R7
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && st_q.count == CNTW'(DEPTH)) |=> $stable(st_q.count));

endmodule

// File: rtl/kbd_matrix.sv
module kbd_matrix
    import kbd_pkg::*;
#(
    parameter int NUM_SENSE  = 7,
    parameter int NUM_STROBE = 11,
    parameter int NUM_SW     = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_STROBE-1:0] strobe_i,
    input  logic                  ev_valid_i,
    input  kbd_event_t            ev_i,
    input  logic                  clear_i,
    input  logic [NUM_SW-1:0]     inv_i,
    output logic [NUM_SENSE-1:0]  sense_o,
    output logic [NUM_SW-1:0]     sw_o
);
    localparam logic [2:0] SW_ROW = 3'(NUM_SENSE);

    typedef struct packed {
        logic [NUM_SENSE-1:0][NUM_STROBE-1:0] bitmap;
        logic [NUM_SENSE-1:0]                 sense;
        logic [NUM_SW-1:0]                    sw;
    } mtx_st_t;

    mtx_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int r = 0; r < NUM_SENSE; r++)
            st_d.sense[r] = |(st_q.bitmap[r] & strobe_i);
        if (clear_i) begin
            st_d.bitmap = '0;
        end else if (ev_valid_i) begin
            if (ev_i.row == SW_ROW) begin
                for (int c = 0; c < NUM_SW; c++)
                    if (ev_i.col == 4'(c))
                        st_d.sw[c] = ~ev_i.rel ^ inv_i[c];
            end else begin
                for (int r = 0; r < NUM_SENSE; r++)
                    for (int c = 0; c < NUM_STROBE; c++)
                        if (ev_i.row == 3'(r) && ev_i.col == 4'(c))
                            st_d.bitmap[r][c] = ~ev_i.rel;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sense_o = st_q.sense;
    assign sw_o    = st_q.sw;

    // R8
    clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (st_q.bitmap == '0));

    // R3
    idle_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i == '0) |=> (sense_o == '0));

    // R4
    sw_row_keeps_matrix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid_i && !clear_i && ev_i.row == SW_ROW) |=> $stable(st_q.bitmap));

endmodule

// File: rtl/kbd_matrix_emu.sv
module kbd_matrix_emu
    import kbd_pkg::*;
#(
    parameter int NUM_SENSE  = 7,
    parameter int NUM_STROBE = 11,
    parameter int NUM_SW     = 5,
    parameter int FIFO_DEPTH = 16,
    parameter int TICK_DIV   = 1562500
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  key_push_i,
    input  logic [7:0]            key_code_i,
    input  logic [NUM_STROBE-1:0] strobe_i,
    input  logic                  release_all_i,
    input  logic                  inv_we_i,
    input  logic [NUM_SW-1:0]     inv_data_i,
    output logic [NUM_SENSE-1:0]  sense_o,
    output logic [NUM_SW-1:0]     switch_o,
    output logic                  overflow_o
);
    typedef struct packed {
        logic [NUM_SW-1:0] inv;
    } cfg_st_t;

    cfg_st_t              cfg_d, cfg_q;
    logic                 tick, fifo_empty, pop;
    logic [EVENT_W-1:0]   head;
    kbd_event_t           head_ev;

    always_comb begin
        cfg_d = cfg_q;
        if (inv_we_i) cfg_d.inv = inv_data_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign pop     = tick && !fifo_empty;
    assign head_ev = kbd_event_t'(head);

    kbd_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    kbd_fifo #(.DEPTH(FIFO_DEPTH), .W(EVENT_W)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (key_push_i),
        .data_i  (key_code_i),
        .pop_i   (pop),
        .data_o  (head),
        .empty_o (fifo_empty),
        .ovf_o   (overflow_o)
    );

    kbd_matrix #(
        .NUM_SENSE  (NUM_SENSE),
        .NUM_STROBE (NUM_STROBE),
        .NUM_SW     (NUM_SW)
    ) u_matrix (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe_i   (strobe_i),
        .ev_valid_i (pop),
        .ev_i       (head_ev),
        .clear_i    (release_all_i),
        .inv_i      (cfg_q.inv),
        .sense_o    (sense_o),
        .sw_o       (switch_o)
    );

    // R6
    sw_only_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(switch_o));

endmodule

// File: tb/kbd_matrix_emu_bench.sv
module kbd_matrix_emu_bench;
    localparam int NS  = 7;
    localparam int NC  = 11;
    localparam int NSW = 5;
    localparam int DEP = 16;
    localparam int DIV = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          key_push = 1'b0;
    logic [7:0]    key_code = '0;
    logic [NC-1:0] strobe = '0;
    logic          release_all = 1'b0;
    logic          inv_we = 1'b0;
    logic [NSW-1:0] inv_data = '0;
    logic [NS-1:0] sense;
    logic [NSW-1:0] sw;
    logic          ovf;

    always #5 clk = ~clk;

    kbd_matrix_emu #(
        .NUM_SENSE(NS), .NUM_STROBE(NC), .NUM_SW(NSW),
        .FIFO_DEPTH(DEP), .TICK_DIV(DIV)
    ) u_kbd_matrix_emu (
        .clk(clk), .rst_n(rst_n), .key_push_i(key_push), .key_code_i(key_code),
        .strobe_i(strobe), .release_all_i(release_all), .inv_we_i(inv_we),
        .inv_data_i(inv_data), .sense_o(sense), .switch_o(sw), .overflow_o(ovf)
    );

    // Behavioural reference
    logic [NC-1:0]  m_bm [NS];
    logic [NS-1:0]  m_sense;
    logic [NSW-1:0] m_sw;
    logic [NSW-1:0] m_inv;
    logic           m_ovf;
    int             m_cnt;
    int             q[$];

    int    checks = 0;
    int    fails  = 0;
    int    strobe_mode = 0;
    int    rng = 32'h1234567;
    string tag = "R3";
    bit    done = 1'b0;

    function automatic void chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endfunction

    task automatic model_update();
        logic [NS-1:0] sn;
        bit tk, popd;
        int ev, row, col;
        bit rel;
        tk = (m_cnt == DIV - 1);
        m_cnt = tk ? 0 : m_cnt + 1;
        for (int r = 0; r < NS; r++) sn[r] = |(m_bm[r] & strobe);
        popd = 0;
        ev = 0;
        if (tk && q.size() > 0) begin ev = q.pop_front(); popd = 1; end
        if (key_push) begin
            if (q.size() < DEP) q.push_back(int'(key_code));
            else m_ovf = 1'b1;
        end
        if (release_all) begin
            for (int r = 0; r < NS; r++) m_bm[r] = '0;
        end else if (popd) begin
            rel = ev[7];
            row = (ev >> 4) & 7;
            col = ev & 15;
            if (row == 7) begin
                if (col < NSW) m_sw[col] = !rel ^ m_inv[col];
            end else if (col < NC) begin
                m_bm[row][col] = !rel;
            end
        end
        if (inv_we) m_inv = inv_data;
        m_sense = sn;
    endtask

    task automatic compare();
        chk(sense == m_sense, {tag, " sense (R3)"}, int'(sense), int'(m_sense));
        chk(sw == m_sw, {tag, " switch (R4)"}, int'(sw), int'(m_sw));
        chk(ovf == m_ovf, {tag, " overflow (R7)"}, int'(ovf), int'(m_ovf));
    endtask

    task automatic step();
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare();
        rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
        case (strobe_mode)
            0: strobe = rng[NC-1:0];
            1: strobe = '1;
            default: strobe = '0;
        endcase
    endtask

    task automatic push(input logic [7:0] code);
        key_push = 1'b1; key_code = code;
        step();
        key_push = 1'b0;
    endtask

    task automatic wait_drain();
        while (q.size() > 0) step();
        repeat (2) step();
    endtask

    initial begin
        for (int r = 0; r < NS; r++) m_bm[r] = '0;
        m_sense = '0; m_sw = '0; m_inv = '0; m_ovf = 1'b0; m_cnt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk(sense == '0, "R1 sense", int'(sense), 0);
        chk(sw == '0, "R1 switch", int'(sw), 0);
        chk(ovf == 1'b0, "R1 overflow", int'(ovf), 0);

        // R9: inversion write
        tag = "R9";
        inv_we = 1'b1; inv_data = 5'b01010;
        step();
        inv_we = 1'b0;

        // R2, R6: matrix presses, applied one per tick
        tag = "R2";
        strobe_mode = 1;
        push(8'h00); push(8'h25); push(8'h6A);
        wait_drain();
        chk(sense == 7'b1000101, "R2 presses visible", int'(sense), 7'b1000101);

        // R3: scanning with changing strobes
        tag = "R3";
        strobe_mode = 0;
        repeat (40) step();

        // R4: switch row with inversion
        tag = "R4";
        push(8'h70); push(8'h71); push(8'h73); push(8'h74);
        wait_drain();
        chk(sw == 5'b10001, "R4 switch press xor inv", int'(sw), 5'b10001);
        push(8'hF1); push(8'hF0);
        wait_drain();

        // R5: out-of-range columns ignored
        tag = "R5";
        strobe_mode = 1;
        push(8'h0B); push(8'h0F); push(8'h75); push(8'h7F);
        wait_drain();
        chk(sense == 7'b1000101, "R5 matrix unchanged", int'(sense), 7'b1000101);

        // R9: new invert only affects later events
        tag = "R9";
        inv_we = 1'b1; inv_data = 5'b00001;
        step();
        inv_we = 1'b0;
        repeat (3) step();
        chk(sw == m_sw, "R9 no retroactive change", int'(sw), int'(m_sw));
        push(8'h72);
        wait_drain();

        // R2: releases
        tag = "R2";
        push(8'h80); push(8'hEA);
        wait_drain();
        chk(sense == 7'b0000100, "R2 releases", int'(sense), 7'b0000100);

        // R8: release-all coinciding with a tick that pops a pending press
        tag = "R8";
        push(8'h33);
        while (m_cnt != DIV - 1) step();
        release_all = 1'b1;
        step();
        release_all = 1'b0;
        repeat (DIV + 2) step();
        chk(sense == '0, "R8 clear wins over same-cycle event", int'(sense), 0);
        chk(q.size() == 0, "R8 event consumed", q.size(), 0);

        // R7: overflow, burst across ticks
        tag = "R7";
        strobe_mode = 0;
        for (int i = 0; i < 22; i++) push(8'h79);
        chk(ovf == 1'b1, "R7 overflow set", int'(ovf), 1);
        wait_drain();
        repeat (5) step();
        chk(ovf == 1'b1, "R7 overflow sticky", int'(ovf), 1);

        // R6: single event lands only on a tick edge
        tag = "R6";
        strobe_mode = 1;
        push(8'h14);
        wait_drain();
        chk(sense == 7'b0000010, "R6 event applied", int'(sense), 7'b0000010);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule